// File: doc/BRIEF.md
# Time-Triggered Transmit Dispatcher

This block decides, tick by tick, whether one network port may begin sending a frame in a cyclic, table-driven network. A local synchronized time value gives the position inside the repeating communication period. A small loadable schedule table holds the offsets at which time-triggered frames must start, and the frame length of each one. While the device is synchronized, the block issues a time-triggered start strobe at each listed offset. When the device acts as a synchronization master, it also issues a synchronization control frame start at the beginning of each period.

Between scheduled starts, the block releases the frame at the head of the event-triggered queue only when the whole frame, including preamble and inter-frame gap, fits before the next scheduled dispatch instant and the wire is idle. No frame is ever cut short: the schedule is assumed non-overlapping, and event-triggered traffic is admitted only into gaps it cannot overrun. The strobe carries a class tag, so the serializer and the queues know which source to drain.

Top module: `tt_dispatch`

## Requirements
- R1: While reset is asserted, and in every cycle with no start, `tx_start` is 0 and `tx_class` is 0. Class codes are 0 = none, 1 = time-triggered, 2 = event-triggered, 3 = synchronization frame.
- R2: No start is issued while `in_sync` is low. After `in_sync` rises, nothing is issued until `cycle_time` next reads 0.
- R3: While running, a start with class 1 is issued one clock after the clock in which `cycle_time` equals the offset of the active entry the read pointer selects. The pointer then moves to the next entry, and it returns to entry 0 after `cycle_time` = PERIOD-1.
- R4: With `is_master` high, a start with class 3 is issued one clock after each running clock in which `cycle_time` is 0. With `is_master` low, class 3 never appears.
- R5: If a master's table holds an entry at offset 0, the synchronization frame wins that tick. The entry is consumed without a time-triggered start, and later entries still fire at their offsets.
- R6: With `et_valid` high, no higher-priority start in the same tick and an idle wire, an event-triggered start (class 2) is issued one clock later exactly when t + (`et_bytes` + 20) × TICKS_PER_BYTE ≤ the next dispatch instant. The next dispatch instant is the offset of the entry the pointer selects.
- R7: Once all active entries of the period are used, the next dispatch instant is PERIOD + offset of entry 0. It is PERIOD alone when `is_master` is high or no entry is active.
- R8: A start decided at tick t keeps the wire busy for d ticks (t … t+d-1), where d = (bytes + 20) × TICKS_PER_BYTE. The bytes are the entry's bytes for class 1, SYNC_BYTES for class 3 and `et_bytes` for class 2. No event-triggered start is decided before tick t+d.
- R9: When `in_sync` drops mid-period, starts stop from the next output clock and the pointer returns to entry 0. Dispatching resumes only at the next `cycle_time` = 0 after `in_sync` is high again.
- R10: A write with `tbl_wr` stores `tbl_off` and `tbl_bytes` at index `tbl_idx`. Only indices below `tbl_count` are active, and they must hold ascending offsets. Entries at or above `tbl_count` never dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of synchronized time per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sync | input | 1 | Device is in a synchronized state |
| is_master | input | 1 | Device acts as synchronization master |
| cycle_time | input | TIME_W | Position inside the period, 0 … PERIOD-1 |
| tbl_wr | input | 1 | Schedule table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_off | input | TIME_W | Dispatch offset written to the entry |
| tbl_bytes | input | LEN_W | Frame length in bytes written to the entry |
| tbl_count | input | PTR_W | Number of active entries |
| et_valid | input | 1 | An event-triggered frame is waiting |
| et_bytes | input | LEN_W | Length in bytes of the waiting frame |
| tx_start | output | 1 | Transmit-start strobe |
| tx_class | output | 2 | Class of the started frame |

## Verification
Every start is decided from the inputs of one tick and appears on `tx_start`/`tx_class` exactly one clock later. The bench therefore drives each tick's inputs on a falling edge and compares the outputs on the next falling edge against a value it computed for that tick. Wire occupancy counts from the tick of the decision, so a frame of d ticks blocks admission through tick t+d-1, and the reference tracks that window across period wraps. The look-ahead boundaries of 0 and 1 spare ticks are reached by sweeping the waiting frame length over every value, with and without the master role.

// File: rtl/tt_disp_pkg.sv
package tt_disp_pkg;

   typedef enum logic [1:0] {
      TXC_NONE = 2'd0,
      TXC_TT   = 2'd1,
      TXC_ET   = 2'd2,
      TXC_SYNC = 2'd3
   } tx_class_e;

   // preamble plus inter-frame gap, in bytes, added to every frame on the wire
   localparam int unsigned WIRE_OVERHEAD_BYTES = 20;

endpackage

// File: rtl/tt_disp_frame_time.sv
module tt_disp_frame_time #(
   parameter int unsigned LEN_W          = 11,
   parameter int unsigned TICKS_PER_BYTE = 8,
   parameter int unsigned DUR_W          = 15
) (
   input  logic [LEN_W-1:0] bytes_in,
   output logic [DUR_W-1:0] ticks_out
);
   import tt_disp_pkg::*;

   logic [DUR_W-1:0] wire_bytes;
   assign wire_bytes = DUR_W'(bytes_in) + DUR_W'(WIRE_OVERHEAD_BYTES);

   // power-of-two byte times reduce to a shift; others need a multiplier
   if ((TICKS_PER_BYTE & (TICKS_PER_BYTE - 1)) == 0) begin : g_shift
      localparam int unsigned SHIFT = $clog2(TICKS_PER_BYTE);
      assign ticks_out = wire_bytes << SHIFT;
   end else begin : g_mult
      assign ticks_out = DUR_W'(wire_bytes * DUR_W'(TICKS_PER_BYTE));
   end

endmodule

// File: rtl/tt_disp_wire.sv
module tt_disp_wire #(
   parameter int unsigned DUR_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DUR_W-1:0] load_ticks,
   output logic             busy
);
   logic [DUR_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_ticks - 1'b1;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign busy = (remain_q != '0);

endmodule

// File: rtl/tt_disp_table.sv
module tt_disp_table #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TIME_W  = 20,
   parameter int unsigned LEN_W   = 11,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned PTR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TIME_W-1:0] wr_off,
   input  logic [LEN_W-1:0]  wr_bytes,
   input  logic [PTR_W-1:0]  count,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic              rd_valid,
   output logic [TIME_W-1:0] rd_off,
   output logic [LEN_W-1:0]  rd_bytes,
   output logic [TIME_W-1:0] first_off
);
   logic [TIME_W-1:0] off_arr [ENTRIES];
   logic [LEN_W-1:0]  len_arr [ENTRIES];
   logic [IDX_W-1:0]  rd_idx;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic [TIME_W-1:0] off_r;
      logic [LEN_W-1:0]  len_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            off_r <= '0;
            len_r <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            off_r <= wr_off;
            len_r <= wr_bytes;
         end
      end
      assign off_arr[i] = off_r;
      assign len_arr[i] = len_r;
   end

   assign rd_valid  = (rd_ptr < count) && (rd_ptr < PTR_W'(ENTRIES));
   assign rd_idx    = rd_valid ? rd_ptr[IDX_W-1:0] : '0;
   assign rd_off    = off_arr[rd_idx];
   assign rd_bytes  = len_arr[rd_idx];
   assign first_off = off_arr[0];

endmodule

// File: rtl/tt_dispatch.sv
module tt_dispatch #(
   parameter int unsigned PERIOD         = 1_000_000,
   parameter int unsigned ENTRIES        = 8,
   parameter int unsigned LEN_W          = 11,
   parameter int unsigned TICKS_PER_BYTE = 8,
   parameter int unsigned SYNC_BYTES     = 64,
   localparam int unsigned TIME_W = $clog2(PERIOD),
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned PTR_W  = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sync,
   input  logic              is_master,
   input  logic [TIME_W-1:0] cycle_time,
   input  logic              tbl_wr,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [TIME_W-1:0] tbl_off,
   input  logic [LEN_W-1:0]  tbl_bytes,
   input  logic [PTR_W-1:0]  tbl_count,
   input  logic              et_valid,
   input  logic [LEN_W-1:0]  et_bytes,
   output logic              tx_start,
   output logic [1:0]        tx_class
);
   import tt_disp_pkg::*;

   localparam int unsigned MAX_TICKS  = ((1 << LEN_W) - 1 + WIRE_OVERHEAD_BYTES) * TICKS_PER_BYTE;
   localparam int unsigned DUR_W      = $clog2(MAX_TICKS + 1);
   localparam int unsigned LA_W       = TIME_W + 1;
   localparam int unsigned SUM_W      = ((DUR_W > LA_W) ? DUR_W : LA_W) + 1;
   localparam logic [DUR_W-1:0] SYNC_TICKS =
      DUR_W'((SYNC_BYTES + WIRE_OVERHEAD_BYTES) * TICKS_PER_BYTE);

   if (PERIOD < 2) begin : g_bad_period
      $error("tt_dispatch: PERIOD must be at least 2");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tt_dispatch: ENTRIES must be at least 2");
   end
   if (TICKS_PER_BYTE < 1) begin : g_bad_tpb
      $error("tt_dispatch: TICKS_PER_BYTE must be at least 1");
   end
   if (SYNC_BYTES >= (1 << LEN_W)) begin : g_bad_sync
      $error("tt_dispatch: SYNC_BYTES must fit in LEN_W bits");
   end

   logic              run_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              rd_valid;
   logic [TIME_W-1:0] rd_off;
   logic [TIME_W-1:0] rd_first;
   logic [LEN_W-1:0]  rd_bytes;
   logic [DUR_W-1:0]  tt_ticks;
   logic [DUR_W-1:0]  et_ticks;
   logic [DUR_W-1:0]  load_ticks;
   logic [LA_W-1:0]   lookahead;
   logic              wire_busy;
   logic              at_start;
   logic              at_end;
   logic              active;
   logic              slot_hit;
   logic              sync_fire;
   logic              tt_fire;
   logic              et_fits;
   logic              et_fire;
   logic              start_any;
   tx_class_e         cls_d;

   tt_disp_table #(
      .ENTRIES (ENTRIES),
      .TIME_W  (TIME_W),
      .LEN_W   (LEN_W),
      .IDX_W   (IDX_W),
      .PTR_W   (PTR_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_wr),
      .wr_idx    (tbl_idx),
      .wr_off    (tbl_off),
      .wr_bytes  (tbl_bytes),
      .count     (tbl_count),
      .rd_ptr    (ptr_q),
      .rd_valid  (rd_valid),
      .rd_off    (rd_off),
      .rd_bytes  (rd_bytes),
      .first_off (rd_first)
   );

   tt_disp_frame_time #(
      .LEN_W          (LEN_W),
      .TICKS_PER_BYTE (TICKS_PER_BYTE),
      .DUR_W          (DUR_W)
   ) u_tt_time (
      .bytes_in  (rd_bytes),
      .ticks_out (tt_ticks)
   );

   tt_disp_frame_time #(
      .LEN_W          (LEN_W),
      .TICKS_PER_BYTE (TICKS_PER_BYTE),
      .DUR_W          (DUR_W)
   ) u_et_time (
      .bytes_in  (et_bytes),
      .ticks_out (et_ticks)
   );

   tt_disp_wire #(
      .DUR_W (DUR_W)
   ) u_wire (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start_any),
      .load_ticks (load_ticks),
      .busy       (wire_busy)
   );

   assign at_start  = (cycle_time == '0);
   assign at_end    = (cycle_time == TIME_W'(PERIOD - 1));
   assign active    = in_sync && (run_q || at_start);
   assign slot_hit  = active && rd_valid && (cycle_time == rd_off);
   assign sync_fire = active && is_master && at_start;
   assign tt_fire   = slot_hit && !sync_fire;

   always_comb begin
      if (rd_valid) begin
         lookahead = LA_W'(rd_off);
      end else if (is_master || (tbl_count == '0)) begin
         lookahead = LA_W'(PERIOD);
      end else begin
         lookahead = LA_W'(PERIOD) + LA_W'(rd_first);
      end
   end

   assign et_fits   = (SUM_W'(cycle_time) + SUM_W'(et_ticks)) <= SUM_W'(lookahead);
   assign et_fire   = active && et_valid && !sync_fire && !slot_hit && !wire_busy && et_fits;
   assign start_any = sync_fire || tt_fire || et_fire;

   always_comb begin
      cls_d      = TXC_NONE;
      load_ticks = et_ticks;
      if (sync_fire) begin
         cls_d      = TXC_SYNC;
         load_ticks = SYNC_TICKS;
      end else if (tt_fire) begin
         cls_d      = TXC_TT;
         load_ticks = tt_ticks;
      end else if (et_fire) begin
         cls_d      = TXC_ET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ptr_q    <= '0;
         tx_start <= 1'b0;
         tx_class <= TXC_NONE;
      end else begin
         run_q    <= active;
         tx_start <= start_any;
         tx_class <= cls_d;
         if (!active || at_end) begin
            ptr_q <= '0;
         end else if (slot_hit) begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tt_dispatch_chk.sv
module tt_dispatch_chk #(
   parameter int unsigned TIME_W = 20,
   parameter int unsigned LA_W   = 21,
   parameter int unsigned DUR_W  = 15,
   parameter int unsigned PTR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_sync,
   input logic              is_master,
   input logic [TIME_W-1:0] cycle_time,
   input logic              tx_start,
   input logic [1:0]        tx_class,
   input logic              wire_busy,
   input logic [LA_W-1:0]   lookahead,
   input logic [DUR_W-1:0]  et_ticks,
   input logic [PTR_W-1:0]  ptr_q
);
   localparam int unsigned SUM_W = ((DUR_W > LA_W) ? DUR_W : LA_W) + 1;

   AST_IDLE_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_start |-> (tx_class == 2'd0));                                            // R1

   AST_QUIET_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!in_sync) |-> !tx_start);                                               // R2

   AST_SYNC_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && (tx_class == 2'd3)) |-> ($past(is_master) && ($past(cycle_time) == '0))); // R4

   AST_ET_FITS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && (tx_class == 2'd2)) |->
         ((SUM_W'($past(cycle_time)) + SUM_W'($past(et_ticks))) <= SUM_W'($past(lookahead)))); // R6

   AST_ET_WIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && (tx_class == 2'd2)) |-> !$past(wire_busy));                       // R8

   AST_PTR_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!in_sync) |-> (ptr_q == '0));                                           // R9

endmodule

bind tt_dispatch tt_dispatch_chk #(
   .TIME_W (TIME_W),
   .LA_W   (LA_W),
   .DUR_W  (DUR_W),
   .PTR_W  (PTR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_sync    (in_sync),
   .is_master  (is_master),
   .cycle_time (cycle_time),
   .tx_start   (tx_start),
   .tx_class   (tx_class),
   .wire_busy  (wire_busy),
   .lookahead  (lookahead),
   .et_ticks   (et_ticks),
   .ptr_q      (ptr_q)
);

// File: tb/tt_dispatch_test.sv
module tt_dispatch_test;

   localparam int P   = 160;
   localparam int E   = 4;
   localparam int LW  = 6;
   localparam int TPB = 1;
   localparam int SB  = 4;
   localparam int TW  = $clog2(P);
   localparam int IW  = $clog2(E);
   localparam int PW  = $clog2(E + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_sync = 1'b0;
   logic          is_master = 1'b0;
   logic [TW-1:0] cycle_time = '0;
   logic          tbl_wr = 1'b0;
   logic [IW-1:0] tbl_idx = '0;
   logic [TW-1:0] tbl_off = '0;
   logic [LW-1:0] tbl_bytes = '0;
   logic [PW-1:0] tbl_count = '0;
   logic          et_valid = 1'b0;
   logic [LW-1:0] et_bytes = '0;
   logic          tx_start;
   logic [1:0]    tx_class;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   int b_off [E];
   int b_len [E];
   int b_cnt = 0;
   int m_run = 0;
   int m_ptr = 0;
   int m_busy = 0;
   int t_now = 0;

   tt_dispatch #(
      .PERIOD         (P),
      .ENTRIES        (E),
      .LEN_W          (LW),
      .TICKS_PER_BYTE (TPB),
      .SYNC_BYTES     (SB)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_sync    (in_sync),
      .is_master  (is_master),
      .cycle_time (cycle_time),
      .tbl_wr     (tbl_wr),
      .tbl_idx    (tbl_idx),
      .tbl_off    (tbl_off),
      .tbl_bytes  (tbl_bytes),
      .tbl_count  (tbl_count),
      .et_valid   (et_valid),
      .et_bytes   (et_bytes),
      .tx_start   (tx_start),
      .tx_class   (tx_class)
   );

   always #10ns clk = ~clk;

   function automatic int wire_ticks(int nbytes);
      return (nbytes + 20) * TPB;
   endfunction

   task automatic compare(int exp_s, int exp_c);
      n_cmp++;
      if ((int'(tx_start) != exp_s) || (int'(tx_class) != exp_c)) begin
         n_bad++;
         $display("FAIL %s tick=%0d start/class actual %0d/%0d expected %0d/%0d",
                  cur_req, t_now, tx_start, tx_class, exp_s, exp_c);
      end
   endtask

   // one tick: drive inputs, predict, wait one clock, compare
   task automatic step();
      int  e_s;
      int  e_c;
      int  d;
      int  nxt;
      bit  act;
      bit  hit;
      cycle_time = TW'(t_now);
      act = in_sync && ((m_run != 0) || (t_now == 0));
      hit = act && (m_ptr < b_cnt) && (t_now == b_off[m_ptr]);
      if (m_ptr < b_cnt) nxt = b_off[m_ptr];
      else               nxt = P + ((is_master || (b_cnt == 0)) ? 0 : b_off[0]);
      e_s = 0; e_c = 0; d = 0;
      if (act && is_master && (t_now == 0)) begin
         e_s = 1; e_c = 3; d = wire_ticks(SB);
      end else if (hit) begin
         e_s = 1; e_c = 1; d = wire_ticks(b_len[m_ptr]);
      end else if (act && et_valid && (m_busy == 0) &&
                   (t_now + wire_ticks(int'(et_bytes)) <= nxt)) begin
         e_s = 1; e_c = 2; d = wire_ticks(int'(et_bytes));
      end
      if (e_s != 0)       m_busy = d - 1;
      else if (m_busy > 0) m_busy--;
      if (!act || (t_now == P - 1)) m_ptr = 0;
      else if (hit)                 m_ptr++;
      m_run = act ? 1 : 0;
      @(negedge clk);
      compare(e_s, e_c);
      t_now = (t_now + 1) % P;
   endtask

   task automatic run_ticks(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic run_until(int target);
      while (t_now != target) step();
   endtask

   // R10: table write while unsynchronized
   task automatic put_entry(int i, int off, int len);
      tbl_wr    = 1'b1;
      tbl_idx   = IW'(i);
      tbl_off   = TW'(off);
      tbl_bytes = LW'(len);
      step();
      tbl_wr    = 1'b0;
      b_off[i]  = off;
      b_len[i]  = len;
   endtask

   task automatic set_count(int c);
      tbl_count = PW'(c);
      b_cnt     = c;
   endtask

   task automatic base_table();
      put_entry(0, 30, 2);
      put_entry(1, 60, 2);
      put_entry(2, 90, 2);
      put_entry(3, 120, 2);
      set_count(4);
   endtask

   initial begin
      for (int i = 0; i < E; i++) begin
         b_off[i] = 0;
         b_len[i] = 0;
      end
      // R1: outputs idle under reset
      repeat (3) @(negedge clk);
      cur_req = "R1";
      compare(0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare(0, 0);

      cur_req = "R10";
      base_table();
      run_until(0);

      // R2: silent while unsynchronized, then waits for period start
      cur_req = "R2";
      run_ticks(P + 50);
      in_sync = 1'b1;
      run_until(0);

      // R3: scheduled starts at each offset, non-master, no queued traffic
      cur_req = "R3";
      run_ticks(2 * P);

      // R4: master adds the synchronization frame at offset 0
      cur_req = "R4";
      is_master = 1'b1;
      run_ticks(2 * P);
      is_master = 1'b0;
      run_ticks(P);

      // R8: shortest queued frames fill gaps back to back
      cur_req = "R8";
      et_valid = 1'b1;
      et_bytes = '0;
      run_ticks(2 * P);

      // R7: fit at the period boundary with exactly 0 and 1 spare ticks
      cur_req = "R7";
      for (int b = 27; b <= 29; b++) begin
         et_bytes = LW'(b);
         run_ticks(P);
         is_master = 1'b1;
         run_ticks(P);
         is_master = 1'b0;
      end

      // R6: every queued length, both roles
      cur_req = "R6";
      for (int b = 0; b < (1 << LW); b++) begin
         et_bytes  = LW'(b);
         is_master = b[0];
         run_ticks(P);
      end
      is_master = 1'b0;
      et_valid  = 1'b0;
      run_until(0);

      // R9: drop synchronization mid-period, restore, resume at next period
      cur_req = "R9";
      run_until(70);
      in_sync = 1'b0;
      run_ticks(10);
      in_sync = 1'b1;
      run_ticks(2 * P);
      et_valid = 1'b1;
      et_bytes = 6'd5;
      run_until(70);
      in_sync = 1'b0;
      run_ticks(3);
      in_sync = 1'b1;
      run_ticks(2 * P);
      et_valid = 1'b0;

      // R5: master with an entry at offset 0
      cur_req = "R5";
      in_sync = 1'b0;
      run_until(0);
      put_entry(0, 0, 2);
      run_until(0);
      in_sync   = 1'b1;
      is_master = 1'b1;
      run_ticks(2 * P);
      et_valid = 1'b1;
      et_bytes = 6'd3;
      run_ticks(P);
      et_valid  = 1'b0;
      is_master = 1'b0;

      // R10: entries beyond the active count never dispatch
      cur_req = "R10";
      in_sync = 1'b0;
      run_ticks(2);
      base_table();
      set_count(2);
      run_until(0);
      in_sync = 1'b1;
      run_ticks(2 * P);
      et_valid = 1'b1;
      et_bytes = 6'd10;
      run_ticks(P);
      in_sync = 1'b0;
      run_ticks(2);
      set_count(0);
      run_until(0);
      in_sync = 1'b1;
      run_ticks(2 * P);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog %s actual running expected finished", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule